// File: doc/BRIEF.md
# LCD Panel Register Initialisation Sequencer

This block brings a parallel-bus display panel out of power-up without software help. A single start pulse sets it running. It first asks the bus master to read panel register 0, which serves as an identification read. It then drives the panel reset line through a high, low, high train, with a fixed millisecond gap after each step. Next it walks a parameter table of programming entries. Each table entry packs a register index, a 16-bit value and a post-write wait in milliseconds.

For every entry the block sends an index cycle and then a data cycle. When the entry's wait is nonzero, the block stalls for that many milliseconds. After the last entry it sends one lone index command, the memory-write index. On acceptance of that command it switches the bus into pixel data-select mode and raises `done`. Both stay high until reset.

Requests leave the block over a valid/ready pair toward a bus master. A millisecond tick is derived from a clock-rate parameter given in kHz, so the parameter value equals the number of clock cycles in one millisecond.

Top module: `lcd_init_seq`

## Requirements
- R1: While `rst_n` is low, and after it rises until a start pulse arrives, the block holds these values: `req_valid`=0, `done`=0, `pix_sel`=0 and `lcd_rst`=1.
- R2: The first request after `start` is a read (`req_kind`=2) of register 0 (`req_word`=0x0000). It is accepted one clock edge after the edge that samples `start`, provided `bus_ready` is high.
- R3: Let C be CLK_KHZ and G be RST_GAP_MS. `lcd_rst` falls G*C+1 edges after the edge that accepts the read. It stays low for G*C+1 cycles. The first index request is accepted G*C+2 edges after the edge on which `lcd_rst` rises again.
- R4: Entry i occupies TABLE[32*i +: 32] as {index[31:24], value[23:8], wait_ms[7:0]}. Entries are sent in increasing i. Each entry is sent as an index request (`req_kind`=0, `req_word`={8'h00,index}) followed by a data request (`req_kind`=1, `req_word`=value).
- R5: Suppose the data request of an entry is accepted at edge a, and `bus_ready` is high. If wait_ms is w>0, the next request is accepted at edge a+w*C+2. If w=0, the next request is accepted at a+1. An index request followed by its data request is accepted on consecutive edges.
- R6: After the last entry, exactly one index request with `req_word`={8'h00,GRAM_IDX} is sent, and no data request follows it. `done` and `pix_sel` rise on the edge that accepts it. They stay high until reset.
- R7: While `req_valid` is high and `bus_ready` is low, `req_valid`, `req_kind` and `req_word` hold their values. Only one request is open at a time.
- R8: A `start` pulse while a run is in progress, or after `done`, changes neither the request order nor the outputs. No request is issued after `done`.
- R9: The millisecond tick restarts whenever a wait is loaded, so a wait of w ms lasts exactly w*C cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse to begin the sequence |
| bus_ready | input | 1 | Bus master can accept a request |
| req_valid | output | 1 | Request offered to the bus master |
| req_kind | output | 2 | 0 index write, 1 data write, 2 register read |
| req_word | output | 16 | Index or value carried by the request |
| lcd_rst | output | 1 | Panel reset line (low = reset) |
| pix_sel | output | 1 | Bus in pixel data-select mode |
| done | output | 1 | Sequence complete |

## Verification
Each result has a fixed due cycle. Every request becomes visible one cycle after the state change that selects it, and is accepted at the first edge where `bus_ready` is high. Waits therefore show up as gaps of 1 or w*C+2 edges between acceptances. The reset line edges follow G*C+1 edges after their trigger, and `done` appears the cycle after the command is accepted. The bench samples on the falling clock edge, stamps every acceptance and every `lcd_rst` edge with a cycle count, and compares the differences with these exact figures. A second run throttles `bus_ready` and adds stray start pulses; in that run it checks only the order and content of the requests.

// File: rtl/lcdseq_pkg.sv
`timescale 1ns/1ps
// Shared types for the panel init sequencer.
// Assumes 32-bit table entries laid out {index8, value16, wait8}.
package lcdseq_pkg;
    localparam int ENT_W = 32;
    localparam int DLY_W = 8;

    typedef enum logic [1:0] {
        K_IDX  = 2'd0,
        K_DATA = 2'd1,
        K_READ = 2'd2
    } req_kind_e;

    typedef enum logic [2:0] {
        S_IDLE, S_RDID, S_TRAIN, S_IDX, S_DATA, S_WAIT, S_CMD, S_FIN
    } seq_state_e;
endpackage

// File: rtl/lcdseq_tick.sv
`timescale 1ns/1ps
// Millisecond prescaler: pulses tick once every CYC_PER_MS cycles.
// Assumes CYC_PER_MS >= 2; clr restarts the count so a wait starts on a fresh ms.
module lcdseq_tick #(
    parameter int CYC_PER_MS = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = $clog2(CYC_PER_MS);
    localparam logic [CW-1:0] LAST = CW'(CYC_PER_MS - 1);

    logic [CW-1:0] cnt;

    assign tick = (cnt == LAST);

    // Free-running modulo counter, restarted by clr.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (tick)     cnt <= '0;
        else               cnt <= cnt + 1'b1;
    end

    // R9
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/lcdseq_timer.sv
`timescale 1ns/1ps
// Millisecond down-counter: load a wait, busy stays high for load_ms*CYC_PER_MS cycles.
// Assumes load_ms is nonzero when load is high.
module lcdseq_timer
    import lcdseq_pkg::*;
#(
    parameter int CYC_PER_MS = 200000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DLY_W-1:0] load_ms,
    output logic             busy
);
    logic             tick;
    logic [DLY_W-1:0] ms_left;

    lcdseq_tick #(.CYC_PER_MS(CYC_PER_MS)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (load),
        .tick  (tick)
    );

    assign busy = (ms_left != '0);

    // Count remaining milliseconds down on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)                 ms_left <= '0;
        else if (load)              ms_left <= load_ms;
        else if (tick && busy)      ms_left <= ms_left - 1'b1;
    end

    // R9
    ms_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ms_left <= $past(ms_left));
endmodule

// File: rtl/lcd_init_seq.sv
`timescale 1ns/1ps
// Panel init sequencer top: id read, reset pulse train, table walk with
// per-entry ms waits, final memory-write index, then pixel mode and done.
// Assumes the bus master completes one request per valid&&ready handshake.
module lcd_init_seq
    import lcdseq_pkg::*;
#(
    parameter int                   N_ENT      = 5,
    parameter logic [N_ENT*ENT_W-1:0] TABLE    = {32'h07_0173_00, 32'h61_0001_00,
                                                  32'h11_0007_32, 32'h10_1290_14,
                                                  32'h01_0100_00},
    parameter int                   CLK_KHZ    = 200000,
    parameter int                   RST_GAP_MS = 50,
    parameter logic [7:0]           GRAM_IDX   = 8'h22
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        bus_ready,
    output logic        req_valid,
    output logic [1:0]  req_kind,
    output logic [15:0] req_word,
    output logic        lcd_rst,
    output logic        pix_sel,
    output logic        done
);
    localparam int PW = (N_ENT > 1) ? $clog2(N_ENT) : 1;
    localparam logic [PW-1:0]    LAST_PTR = PW'(N_ENT - 1);
    localparam logic [DLY_W-1:0] GAP_MS   = DLY_W'(RST_GAP_MS);

    seq_state_e       state;
    logic [PW-1:0]    ptr;
    logic [1:0]       phase;
    logic             accept, t_load, t_busy, last;
    logic [DLY_W-1:0] t_ms;
    logic [ENT_W-1:0] ent;
    req_kind_e        kind;

    assign ent    = TABLE[ptr*ENT_W +: ENT_W];
    assign last   = (ptr == LAST_PTR);
    assign accept = req_valid && bus_ready;

    lcdseq_timer #(.CYC_PER_MS(CLK_KHZ)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (t_load),
        .load_ms (t_ms),
        .busy    (t_busy)
    );

    // Request presented in each issuing state.
    always_comb begin
        req_valid = 1'b0;
        kind      = K_IDX;
        req_word  = 16'h0000;
        case (state)
            S_RDID: begin req_valid = 1'b1; kind = K_READ; end
            S_IDX:  begin req_valid = 1'b1; req_word = {8'h00, ent[31:24]}; end
            S_DATA: begin req_valid = 1'b1; kind = K_DATA; req_word = ent[23:8]; end
            S_CMD:  begin req_valid = 1'b1; req_word = {8'h00, GRAM_IDX}; end
            default: ;
        endcase
    end
    assign req_kind = kind;

    // Timer load requests: reset-train gaps and per-entry waits.
    always_comb begin
        t_load = 1'b0;
        t_ms   = GAP_MS;
        if (state == S_RDID && accept) t_load = 1'b1;
        else if (state == S_TRAIN && !t_busy && phase != 2'd2) t_load = 1'b1;
        else if (state == S_DATA && accept && ent[7:0] != '0) begin
            t_load = 1'b1;
            t_ms   = ent[7:0];
        end
    end

    // Main sequencing state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            ptr     <= '0;
            phase   <= 2'd0;
            lcd_rst <= 1'b1;
            pix_sel <= 1'b0;
            done    <= 1'b0;
        end else begin
            case (state)
                S_IDLE: if (start) state <= S_RDID;
                S_RDID: if (accept) begin
                    state <= S_TRAIN;
                    phase <= 2'd0;
                end
                S_TRAIN: if (!t_busy) begin
                    case (phase)
                        2'd0:    begin lcd_rst <= 1'b0; phase <= 2'd1; end
                        2'd1:    begin lcd_rst <= 1'b1; phase <= 2'd2; end
                        default: begin state <= S_IDX; ptr <= '0; end
                    endcase
                end
                S_IDX:  if (accept) state <= S_DATA;
                S_DATA: if (accept) begin
                    if (ent[7:0] != '0) state <= S_WAIT;
                    else if (last)      state <= S_CMD;
                    else begin
                        state <= S_IDX;
                        ptr   <= ptr + 1'b1;
                    end
                end
                S_WAIT: if (!t_busy) begin
                    if (last) state <= S_CMD;
                    else begin
                        state <= S_IDX;
                        ptr   <= ptr + 1'b1;
                    end
                end
                S_CMD: if (accept) begin
                    state   <= S_FIN;
                    pix_sel <= 1'b1;
                    done    <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !bus_ready |=> req_valid && $stable(req_word) && $stable(req_kind));
    // R6
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done && pix_sel);
    // R6
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(accept && req_kind == 2'd0 && req_word == {8'h00, GRAM_IDX}));
    // R8
    quiet_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_valid);
    // R3
    rst_train_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_rst) |-> !done && !req_valid);
endmodule

// File: tb/sim_lcd_init_seq.sv
`timescale 1ns/1ps
// Bench for lcd_init_seq: vector table of expected requests and gaps,
// then directed reset, throttled-ready and stray-start checks.
module sim_lcd_init_seq;
    localparam int C = 20;
    localparam int G = 3;
    localparam int N = 5;
    localparam logic [N*32-1:0] TAB = {32'h07_0173_00, 32'h52_013F_01,
                                       32'h30_0504_00, 32'h13_0000_02,
                                       32'h03_A1B2_00};
    localparam int NV = 12;
    // {kind, word, gap to previous acceptance}
    localparam logic [33:0] VEC [NV] = '{
        {2'd2, 16'h0000, 16'd0},
        {2'd0, 16'h0003, 16'(3*G*C+4)},
        {2'd1, 16'hA1B2, 16'd1},
        {2'd0, 16'h0013, 16'd1},
        {2'd1, 16'h0000, 16'd1},
        {2'd0, 16'h0030, 16'(2*C+2)},
        {2'd1, 16'h0504, 16'd1},
        {2'd0, 16'h0052, 16'd1},
        {2'd1, 16'h013F, 16'd1},
        {2'd0, 16'h0007, 16'(1*C+2)},
        {2'd1, 16'h0173, 16'd1},
        {2'd0, 16'h0022, 16'd1}
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, throttle = 1'b0;
    logic bus_ready, req_valid, lcd_rst, pix_sel, done;
    logic [1:0]  req_kind;
    logic [15:0] req_word;
    int cyc = 0, tests = 0, fails = 0;
    int nlog = 0, fall_cyc = 0, rise_cyc = 0;
    logic [1:0]  lk [32];
    logic [15:0] lw [32];
    int          lc [32];
    logic prev_rst = 1'b1;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign bus_ready = throttle ? (cyc % 3 != 0) : 1'b1;

    lcd_init_seq #(.N_ENT(N), .TABLE(TAB), .CLK_KHZ(C), .RST_GAP_MS(G)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .bus_ready(bus_ready),
        .req_valid(req_valid), .req_kind(req_kind), .req_word(req_word),
        .lcd_rst(lcd_rst), .pix_sel(pix_sel), .done(done)
    );

    // Log every handshake and reset-line edge, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && req_valid && bus_ready && nlog < 32) begin
            lk[nlog] = req_kind; lw[nlog] = req_word; lc[nlog] = cyc;
            nlog = nlog + 1;
        end
        if (prev_rst && !lcd_rst) fall_cyc = cyc;
        if (!prev_rst && lcd_rst) rise_cyc = cyc;
        prev_rst = lcd_rst;
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", req_valid, 0);
        chk("R1 done in reset", done, 0);
        chk("R1 pix_sel in reset", pix_sel, 0);
        chk("R1 lcd_rst in reset", lcd_rst, 1);
        rst_n = 1'b1;
        nlog = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 20000) begin @(negedge clk); n++; end
        if (!done) chk("watchdog R6", 0, 1);
    endtask

    initial begin
        // Run A: ready always high, exact gaps.
        do_reset();
        repeat (5) @(negedge clk);
        chk("R1 idle without start", req_valid, 0);
        chk("R1 no request logged", nlog, 0);
        pulse_start();
        wait_done();
        @(negedge clk);
        chk("R6 request count", nlog, NV);
        for (int i = 0; i < NV; i++) begin
            chk("R2 R4 R6 kind", lk[i], VEC[i][33:32]);
            chk("R2 R4 R6 word", lw[i], VEC[i][31:16]);
            if (i > 0) chk("R3 R5 R9 gap", lc[i] - lc[i-1], VEC[i][15:0]);
        end
        chk("R3 fall after read", fall_cyc - lc[0], G*C+2);
        chk("R3 low width", rise_cyc - fall_cyc, G*C+1);
        chk("R3 first index after rise", lc[1] - rise_cyc, G*C+1);
        chk("R6 pix_sel", pix_sel, 1);
        // Start after done is ignored.
        pulse_start();
        repeat (40) @(negedge clk);
        chk("R8 no request after done", nlog, NV);
        chk("R8 done held", done, 1);
        chk("R6 pix_sel held", pix_sel, 1);

        // Run B: throttled ready and a stray start mid-run.
        do_reset();
        throttle = 1'b1;
        pulse_start();
        repeat (30) @(negedge clk);
        pulse_start();
        repeat (150) @(negedge clk);
        pulse_start();
        wait_done();
        repeat (10) @(negedge clk);
        chk("R7 R8 request count throttled", nlog, NV);
        for (int i = 0; i < NV; i++) begin
            chk("R7 throttled kind", lk[i], VEC[i][33:32]);
            chk("R7 throttled word", lw[i], VEC[i][31:16]);
        end
        chk("R8 lcd_rst high at end", lcd_rst, 1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule